// File: doc/BRIEF.md
# Nibble-Serial Ethernet FCS Generator and Checker

This block computes the 32-bit Ethernet frame check sequence over a frame that arrives four bits at a time. The frame covers the destination address, the source address, the length/type field and the payload, with any pad bytes included. Each byte enters as two nibbles, the low nibble first. Inside each nibble the CRC register takes the bits least significant first, which is the order Ethernet puts them on the wire. At the start of a frame the register is preset to all ones, and it advances by one nibble for each valid input cycle.

In transmit mode the block forwards the frame nibbles with one cycle of delay. When the insert enable is high, it follows the last data nibble with the eight nibbles of the complemented CRC. When the insert enable is low, the frame passes through unchanged. In receive mode the incoming frame carries its own FCS at the end, and the block runs that FCS through the register too. One cycle after the last nibble it reports whether the register holds the fixed good-frame residue. A downstream buffer uses the discard flag to drop a failed frame, and the check enable can turn that flag off so that every frame is kept.

The upstream source must hold its valid input low for the eight cycles that follow the end of a frame in transmit mode while insertion is enabled. During those cycles the appended nibbles occupy the output.

Top module: `fcs_nibble_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, chk_done and frame_drop are low.
- R2: The CRC uses the reflected polynomial 0xEDB88320 and is preset to 0xFFFFFFFF when in_sof is high. It advances one nibble per valid cycle, bit 0 of in_nib first, and the low nibble of each byte comes before the high nibble. The bytes 0x31..0x39 ("123456789") therefore give FCS 0xCBF43926.
- R3: Every input nibble appears on out_nib in the cycle after it is accepted, in the same order, with out_valid high. out_sof marks the first nibble.
- R4: In transmit mode (tx_mode=1) with ins_en=1, eight FCS nibbles follow the last data nibble with no gap. Nibble k is bits 4k+3..4k of the ones' complement of the final CRC. out_eof is high only on the eighth of them.
- R5: In transmit mode with ins_en=0, no nibble is appended and out_eof is high on the last data nibble.
- R6: In receive mode (tx_mode=0), chk_done pulses for one cycle in the cycle after the in_eof nibble. chk_ok is high exactly when the register, with the received FCS included, equals 0xDEBB20E3, which is the bit-reversed form of 0xC704DD7B.
- R7: In receive mode frame_drop pulses together with chk_done when the check fails and chk_en=1. With chk_en=0, frame_drop stays low.
- R8: chk_done never pulses for a frame received in transmit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input nibble valid |
| in_sof | input | 1 | First nibble of a frame |
| in_eof | input | 1 | Last nibble of a frame |
| in_nib | input | 4 | Input nibble |
| tx_mode | input | 1 | 1 = transmit (append), 0 = receive (check) |
| ins_en | input | 1 | Append FCS in transmit mode |
| chk_en | input | 1 | Allow discard of failed received frames |
| out_valid | output | 1 | Output nibble valid |
| out_sof | output | 1 | First output nibble of a frame |
| out_eof | output | 1 | Last output nibble of a frame |
| out_nib | output | 4 | Output nibble |
| chk_done | output | 1 | Receive check result valid |
| chk_ok | output | 1 | Receive check passed |
| frame_drop | output | 1 | Discard the received frame |

## Verification
On every cycle the assertions check five things. Forwarded nibbles follow their inputs by one cycle. The end marker waits through the appended nibbles when insertion is on and lands on the last data nibble when it is off. Check results appear only after a receive-mode end nibble, and the discard flag needs a failed check with the enable set. The input also stays idle while the append runs. The arithmetic cannot be seen cycle by cycle, so only the directed scenarios show it: the CRC values compared against a bitwise reference over random frames, the known-vector FCS, the nibble order of the appended FCS, and the pass or fail verdict on intact and corrupted frames.

// File: rtl/fcs_pkg.sv
// Package: constants shared by the nibble-serial FCS unit.
// Assumes the reflected (LSB-first) form of the Ethernet CRC-32.
package fcs_pkg;
    localparam int          CRC_W    = 32;
    localparam int          NIB_W    = 4;
    localparam int          FCS_NIBS = CRC_W / NIB_W;
    localparam logic [31:0] POLY     = 32'hEDB88320;
    localparam logic [31:0] PRESET   = 32'hFFFFFFFF;
    localparam logic [31:0] RESIDUE  = 32'hDEBB20E3;
endpackage

// File: rtl/fcs_crc_reg.sv
// CRC register: folds one nibble per valid cycle into a reflected CRC.
// Assumes bit 0 of the nibble is the first bit on the wire; sof restarts
// the register from the preset value inside the same update.
module fcs_crc_reg #(
    parameter int               CRC_W  = fcs_pkg::CRC_W,
    parameter int               NIB_W  = fcs_pkg::NIB_W,
    parameter logic [CRC_W-1:0] POLY   = fcs_pkg::POLY,
    parameter logic [CRC_W-1:0] PRESET = fcs_pkg::PRESET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_vld,
    input  logic             nib_sof,
    input  logic [NIB_W-1:0] nib,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_nxt
);
    logic [CRC_W-1:0] work;

    // Next value: NIB_W single-bit LFSR steps, LSB first.
    always_comb begin
        work = nib_sof ? PRESET : crc_q;
        for (int b = 0; b < NIB_W; b++) begin
            work = (work[0] ^ nib[b]) ? ((work >> 1) ^ POLY) : (work >> 1);
        end
        crc_nxt = work;
    end

    // State: load the next value on every accepted nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_q <= PRESET;
        else if (nib_vld) crc_q <= crc_nxt;
    end
endmodule

// File: rtl/fcs_append.sv
// FCS appender: after start, emits the complemented CRC as a run of
// nibbles, least significant nibble first. Assumes crc_in holds steady
// while busy (no new input nibbles arrive).
module fcs_append #(
    parameter int CRC_W = fcs_pkg::CRC_W,
    parameter int NIB_W = fcs_pkg::NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CRC_W-1:0] crc_in,
    output logic             busy,
    output logic             last,
    output logic [NIB_W-1:0] nib
);
    localparam int NIBS  = CRC_W / NIB_W;
    localparam int CNT_W = $clog2(NIBS);

    logic [CNT_W-1:0] cnt;

    // Sequencer: run the nibble index from 0 to NIBS-1 once per start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(NIBS - 1)) busy <= 1'b0;
        end
    end

    // Select: current nibble of the inverted CRC and the end flag.
    always_comb begin
        nib  = ~crc_in[cnt*NIB_W +: NIB_W];
        last = busy && (cnt == CNT_W'(NIBS - 1));
    end
endmodule

// File: rtl/fcs_rx_judge.sv
// Receive judge: at the last nibble of a received frame, compares the
// updated CRC with the good-frame residue and registers the verdict.
module fcs_rx_judge #(
    parameter int               CRC_W   = fcs_pkg::CRC_W,
    parameter logic [CRC_W-1:0] RESIDUE = fcs_pkg::RESIDUE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic             chk_en,
    input  logic [CRC_W-1:0] crc_nxt,
    output logic             done,
    output logic             ok,
    output logic             drop
);
    logic match;

    // Compare: register value including the FCS against the residue.
    always_comb match = (crc_nxt == RESIDUE);

    // Verdict: one-cycle pulse of done, with ok and a gated drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            ok   <= 1'b0;
            drop <= 1'b0;
        end else begin
            done <= eval;
            ok   <= eval && match;
            drop <= eval && !match && chk_en;
        end
    end
endmodule

// File: rtl/fcs_nibble_unit.sv
// Top: nibble-serial Ethernet FCS unit. Forwards frame nibbles with one
// cycle delay; in transmit mode appends the FCS, in receive mode checks it.
// Assumes tx_mode, ins_en and chk_en are stable within a frame and that
// in_valid stays low while an FCS append is running.
module fcs_nibble_unit #(
    parameter int NIB_W = fcs_pkg::NIB_W,
    parameter int CRC_W = fcs_pkg::CRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [NIB_W-1:0] in_nib,
    input  logic             tx_mode,
    input  logic             ins_en,
    input  logic             chk_en,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eof,
    output logic [NIB_W-1:0] out_nib,
    output logic             chk_done,
    output logic             chk_ok,
    output logic             frame_drop
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;
    logic             app_start;
    logic             app_busy;
    logic             app_last;
    logic [NIB_W-1:0] app_nib;
    logic             rx_eval;
    logic             append_on;

    // Frame-end decode for the two modes.
    always_comb begin
        append_on = tx_mode && ins_en;
        app_start = in_valid && in_eof && append_on;
        rx_eval   = in_valid && in_eof && !tx_mode;
    end

    fcs_crc_reg #(.CRC_W(CRC_W), .NIB_W(NIB_W)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .nib_vld (in_valid),
        .nib_sof (in_sof),
        .nib     (in_nib),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    fcs_append #(.CRC_W(CRC_W), .NIB_W(NIB_W)) u_app (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (app_start),
        .crc_in (crc_q),
        .busy   (app_busy),
        .last   (app_last),
        .nib    (app_nib)
    );

    fcs_rx_judge #(.CRC_W(CRC_W)) u_judge (
        .clk     (clk),
        .rst_n   (rst_n),
        .eval    (rx_eval),
        .chk_en  (chk_en),
        .crc_nxt (crc_nxt),
        .done    (chk_done),
        .ok      (chk_ok),
        .drop    (frame_drop)
    );

    // Output stage: appended FCS nibbles take priority over forwarded data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_nib   <= '0;
        end else if (app_busy) begin
            out_valid <= 1'b1;
            out_sof   <= 1'b0;
            out_eof   <= app_last;
            out_nib   <= app_nib;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_valid && in_sof;
            out_eof   <= in_valid && in_eof && !append_on;
            out_nib   <= in_valid ? in_nib : out_nib;
        end
    end
endmodule

// File: rtl/fcs_nibble_unit_chk.sv
// Checker: temporal properties of the FCS unit, bound to the top module.
module fcs_nibble_unit_chk #(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic             in_eof,
    input logic [NIB_W-1:0] in_nib,
    input logic             tx_mode,
    input logic             ins_en,
    input logic             chk_en,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_eof,
    input logic [NIB_W-1:0] out_nib,
    input logic             chk_done,
    input logic             chk_ok,
    input logic             frame_drop,
    input logic             app_busy
);
    // R3: an accepted nibble shows up unchanged one cycle later.
    p_forward_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> (out_valid && out_nib == $past(in_nib)));

    // R4: no end marker on the last data nibble when the FCS follows.
    p_eof_deferred_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_eof && tx_mode && ins_en) |-> (out_valid && !out_eof));

    // R4: upstream stays idle while the FCS is appended.
    p_idle_during_append_r4: assert property (@(posedge clk) disable iff (!rst_n)
        app_busy |-> !in_valid);

    // R5: without insertion the end marker sits on the last data nibble.
    p_eof_on_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_eof && tx_mode && !ins_en) |-> out_eof);

    // R6: a verdict only follows a receive-mode end nibble.
    p_done_after_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> $past(in_valid && in_eof && !tx_mode));

    // R7: discard needs a failed check with the enable set.
    p_drop_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_drop |-> (chk_done && !chk_ok && $past(chk_en)));

    // R8: transmit frames produce no verdict.
    p_tx_no_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && tx_mode) |=> !chk_done);

    // R3: a start marker always comes with valid data.
    p_sof_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);
endmodule

bind fcs_nibble_unit fcs_nibble_unit_chk #(.NIB_W(NIB_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .in_nib     (in_nib),
    .tx_mode    (tx_mode),
    .ins_en     (ins_en),
    .chk_en     (chk_en),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .out_eof    (out_eof),
    .out_nib    (out_nib),
    .chk_done   (chk_done),
    .chk_ok     (chk_ok),
    .frame_drop (frame_drop),
    .app_busy   (app_busy)
);

// File: tb/test_fcs_nibble_unit.sv
// Directed bench: one task per scenario, bitwise reference CRC.
module test_fcs_nibble_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_sof, in_eof;
    logic [3:0] in_nib;
    logic       tx_mode, ins_en, chk_en;
    logic       out_valid, out_sof, out_eof;
    logic [3:0] out_nib;
    logic       chk_done, chk_ok, frame_drop;

    always #10 clk = ~clk;

    fcs_nibble_unit i_fcs_nibble_unit (.*);

    int checks = 0;
    int errors = 0;
    bit fin    = 1'b0;

    logic [7:0] frm [0:111];
    logic [3:0] cap [$];
    int sof_at, eof_at, eof_cnt, done_cnt, drop_cnt;
    bit ok_last;

    // Monitor: capture outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (out_sof) sof_at = cap.size();
                cap.push_back(out_nib);
                if (out_eof) begin
                    eof_at = cap.size() - 1;
                    eof_cnt++;
                end
            end
            if (chk_done) begin
                done_cnt++;
                ok_last = chk_ok;
            end
            if (frame_drop) drop_cnt++;
        end
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ frm[i][b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic clear_mon();
        cap.delete();
        sof_at = -1; eof_at = -1; eof_cnt = 0;
        done_cnt = 0; drop_cnt = 0; ok_last = 1'b0;
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            for (int h = 0; h < 2; h++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_nib   = h ? frm[i][7:4] : frm[i][3:0];
                in_sof   = (i == 0 && h == 0);
                in_eof   = (i == n - 1 && h == 1);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic fill_random(input int n);
        for (int i = 0; i < n; i++) frm[i] = 8'($urandom);
    endtask

    // Compare forwarded data and (optionally) an expected FCS run.
    task automatic check_tx(input int n, input bit with_fcs, input logic [31:0] fcs);
        int bad_d = -1;
        int bad_f = -1;
        int total = 2 * n + (with_fcs ? 8 : 0);
        chk(cap.size() == total, with_fcs ? "R4" : "R5", "nibble count", cap.size(), total);
        if (cap.size() != total) return;
        for (int i = 0; i < 2 * n; i++)
            if (cap[i] != (i[0] ? frm[i/2][7:4] : frm[i/2][3:0]) && bad_d < 0) bad_d = i;
        chk(bad_d < 0, "R3", "data nibble index", bad_d, -1);
        chk(sof_at == 0, "R3", "sof position", sof_at, 0);
        chk(eof_cnt == 1 && eof_at == total - 1, with_fcs ? "R4" : "R5",
            "eof position", eof_at, total - 1);
        if (with_fcs) begin
            for (int k = 0; k < 8; k++)
                if (cap[2*n+k] != fcs[4*k +: 4] && bad_f < 0) bad_f = k;
            chk(bad_f < 0, "R2", "fcs nibble index", bad_f, -1);
        end
        chk(done_cnt == 0, "R8", "verdicts in transmit", done_cnt, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        in_nib = '0; tx_mode = 1'b1; ins_en = 1'b1; chk_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(!out_valid && !chk_done && !frame_drop, "R1", "outputs in reset",
            {out_valid, chk_done, frame_drop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !chk_done && !frame_drop, "R1", "outputs after reset",
            {out_valid, chk_done, frame_drop}, 0);
    endtask

    task automatic t_known_vector();
        for (int i = 0; i < 9; i++) frm[i] = 8'h31 + 8'(i);
        tx_mode = 1'b1; ins_en = 1'b1;
        clear_mon(); send(9);
        check_tx(9, 1'b1, 32'hCBF43926); // R2 known vector
    endtask

    task automatic t_tx_insert(input int n);
        fill_random(n);
        tx_mode = 1'b1; ins_en = 1'b1;
        clear_mon(); send(n);
        check_tx(n, 1'b1, ref_crc(n)); // R4 append
    endtask

    task automatic t_tx_plain(input int n);
        fill_random(n);
        tx_mode = 1'b1; ins_en = 1'b0;
        clear_mon(); send(n);
        check_tx(n, 1'b0, 32'h0); // R5 no append
    endtask

    task automatic t_rx(input int n, input bit corrupt, input bit cen);
        logic [31:0] f;
        fill_random(n);
        f = ref_crc(n);
        for (int k = 0; k < 4; k++) frm[n+k] = f[8*k +: 8];
        if (corrupt) begin
            int p = int'($urandom % 32'(n));
            frm[p] = frm[p] ^ (8'h1 << ($urandom % 8));
        end
        tx_mode = 1'b0; ins_en = 1'b1; chk_en = cen;
        clear_mon(); send(n + 4);
        chk(done_cnt == 1, "R6", "verdict count", done_cnt, 1);
        chk(ok_last == !corrupt, "R6", "check result", ok_last, !corrupt);
        chk(drop_cnt == int'(corrupt && cen), "R7", "discard pulses", drop_cnt,
            int'(corrupt && cen));
        chk(cap.size() == 2 * (n + 4), "R3", "receive forward count", cap.size(), 2 * (n + 4));
        chk(eof_at == 2 * (n + 4) - 1, "R3", "receive eof position", eof_at, 2 * (n + 4) - 1);
        chk_en = 1'b1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_known_vector();
        t_tx_insert(1);
        t_tx_insert(100);
        for (int r = 0; r < 10; r++) t_tx_insert(1 + int'($urandom % 100));
        t_tx_plain(1);
        for (int r = 0; r < 3; r++) t_tx_plain(1 + int'($urandom % 100));
        t_rx(1, 1'b0, 1'b1);
        t_rx(64, 1'b0, 1'b1);
        for (int r = 0; r < 6; r++) t_rx(1 + int'($urandom % 100), 1'b0, 1'b1);
        t_rx(46, 1'b1, 1'b1);
        t_rx(1 + int'($urandom % 100), 1'b1, 1'b1);
        t_rx(30, 1'b1, 1'b0);
        t_rx(12, 1'b0, 1'b0);
        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule